// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is one 32-line general-purpose I/O bank. Software reaches it through a flat 32-bit register port with an address, a write strobe, write data and combinational read data. Each line works in one of three modes: general input, general output, or interrupt input. Every pin input passes through a two-flop synchroniser. The synchronised value feeds both the input data register and a small sensing state machine for that line.

For an interrupt line, software sets polarity, edge or level sensing, and two-edge detection. The line's pending bit then drives one combined interrupt output through an enable mask. The mask has two write paths: writing zeros to the mask register disables lines, and writing ones to a separate unmask register enables them. The pending register is cleared by writing ones.

The sensing machine has five states. SNS_OFF is the line in general mode. SNS_LVL_QUIET and SNS_LVL_ACTIVE cover level sensing. SNS_EDG_ARMED and SNS_EDG_LATCHED cover edge sensing. The transitions are:
- off: the mode bit is low.
- level-follow: the qualified level decides QUIET or ACTIVE every cycle.
- arm: edge mode with no event, or a clear without an event.
- latch: an edge event in edge mode.
- hold: LATCHED with no clear.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, pin_oe and pin_out are 0, and irq_o is 0.
- R2: These offsets read back what was last written: mode select at 0x00 (1 = interrupt input), direction at 0x04 (1 = output), output data at 0x08, polarity at 0x20 (1 = active-low or falling edge), edge select at 0x24 (1 = edge, 0 = level) and two-edge select at 0x4C. Offsets 0x14 and 0x1C read 0, and so does any unmapped offset.
- R3: pin_oe[i] equals direction[i] AND NOT mode[i]. pin_out[i] equals output data[i] AND pin_oe[i].
- R4: Input data at 0x0C shows the pin two rising edges after it changes, and not after one.
- R5: For a level-sensed interrupt line, status (0x10) bit i equals pin[i] XOR polarity[i], three rising edges after the pin changes. Writing the clear register does not drop it while the level is active.
- R6: For an edge-sensed line with two-edge off, a rising pin sets status when polarity is 0 and a falling pin sets it when polarity is 1. The bit then stays set until it is cleared.
- R7: With edge select 1 and two-edge 1, either pin transition sets status, whatever the polarity.
- R8: Writing 1s to offset 0x14 clears those edge-latched status bits. Bits written as 0 are unchanged.
- R9: If an edge event and a clear of the same line arrive at the same clock edge, the status bit ends set.
- R10: A write to 0x18 ANDs the enable mask with the write data. A write to 0x1C ORs the write data into the mask. Reading 0x18 returns the mask.
- R11: irq_o is 1 exactly when some bit of (status AND mask) is 1.
- R12: A line with mode bit 0 has status 0 whatever its pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, takes effect on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the rising edge that samples it, so readback is due at the next falling edge. A pin change appears in input data after two rising edges, and in status and irq_o after three. The bench drives inputs on falling edges and counts rising edges before it samples. For R4 it checks one edge early as well as on time. For R9 it lines up the clear write with the third edge after the pin change. The main sweep covers all eight combinations of polarity, edge and two-edge over fixed pin patterns. A bitwise model of status, written only from the requirements, gives the expected values.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

    localparam int OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_MODE   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_DOUT   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_DIN    = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CLR    = 8'h14;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h18;
    localparam logic [OFS_W-1:0] OFS_UNMASK = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_POL    = 8'h20;
    localparam logic [OFS_W-1:0] OFS_EDGE   = 8'h24;
    localparam logic [OFS_W-1:0] OFS_BOTH   = 8'h4C;

    typedef enum logic [2:0] {
        SNS_OFF         = 3'd0,
        SNS_LVL_QUIET   = 3'd1,
        SNS_LVL_ACTIVE  = 3'd2,
        SNS_EDG_ARMED   = 3'd3,
        SNS_EDG_LATCHED = 3'd4
    } sns_state_e;

    typedef struct packed {
        logic irq_en;
        logic neg;
        logic edge_sel;
        logic both;
    } line_cfg_t;

endpackage

// File: rtl/gsb_sync.sv
module gsb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] lvl_d_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[LAST];
    end

    assign lvl_o   = chain[LAST];
    assign lvl_d_o = prev_q;

endmodule

// File: rtl/gsb_line_sense.sv
module gsb_line_sense
    import gsb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_cfg_t cfg,
    input  logic      lvl,
    input  logic      lvl_d,
    input  logic      clr,
    output logic      pend
);
    sns_state_e state_q, state_d;
    logic       q_now, q_old, evt;

    assign q_now = lvl ^ cfg.neg;
    assign q_old = lvl_d ^ cfg.neg;
    assign evt   = cfg.both ? (lvl ^ lvl_d) : (q_now & ~q_old);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!cfg.irq_en) begin
            state_d = SNS_OFF;
        end else if (!cfg.edge_sel) begin
            state_d = q_now ? SNS_LVL_ACTIVE : SNS_LVL_QUIET;
        end else begin
            unique case (state_q)
                SNS_EDG_LATCHED: state_d = (evt || !clr) ? SNS_EDG_LATCHED : SNS_EDG_ARMED;
                default:         state_d = evt ? SNS_EDG_LATCHED : SNS_EDG_ARMED;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SNS_LVL_ACTIVE,
            SNS_EDG_LATCHED: pend = 1'b1;
            default:         pend = 1'b0;
        endcase
    end

    // R9
    evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.irq_en && cfg.edge_sel && evt && clr) |=> pend);

    // R6
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.irq_en && cfg.edge_sel && pend && !clr) |=> pend);

    // R12
    off_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.irq_en |=> !pend);

endmodule

// File: rtl/gsb_regs.sv
module gsb_regs
    import gsb_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  pend,
    output logic [W-1:0]  mode,
    output logic [W-1:0]  dir,
    output logic [W-1:0]  dout,
    output logic [W-1:0]  neg,
    output logic [W-1:0]  edge_sel,
    output logic [W-1:0]  both,
    output logic [W-1:0]  mask,
    output logic [W-1:0]  clr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= '0;
            dir      <= '0;
            dout     <= '0;
            neg      <= '0;
            edge_sel <= '0;
            both     <= '0;
            mask     <= '0;
        end else if (wr_en) begin
            case (addr)
                AW'(OFS_MODE):   mode     <= wdata;
                AW'(OFS_DIR):    dir      <= wdata;
                AW'(OFS_DOUT):   dout     <= wdata;
                AW'(OFS_POL):    neg      <= wdata;
                AW'(OFS_EDGE):   edge_sel <= wdata;
                AW'(OFS_BOTH):   both     <= wdata;
                AW'(OFS_MASK):   mask     <= mask & wdata;
                AW'(OFS_UNMASK): mask     <= mask | wdata;
                default: ;
            endcase
        end
    end

    assign clr = (wr_en && addr == AW'(OFS_CLR)) ? wdata : '0;

    always_comb begin
        case (addr)
            AW'(OFS_MODE): rdata = mode;
            AW'(OFS_DIR):  rdata = dir;
            AW'(OFS_DOUT): rdata = dout;
            AW'(OFS_DIN):  rdata = din;
            AW'(OFS_STAT): rdata = pend;
            AW'(OFS_MASK): rdata = mask;
            AW'(OFS_POL):  rdata = neg;
            AW'(OFS_EDGE): rdata = edge_sel;
            AW'(OFS_BOTH): rdata = both;
            default:       rdata = '0;
        endcase
    end

    // R10
    mask_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFS_MASK)) |=> ((mask & ~$past(wdata)) == '0));

    // R10
    unmask_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFS_UNMASK)) |=> ((mask & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gsb_pkg::*;
#(
    parameter int W     = 32,
    parameter int AW    = 8,
    parameter int SYNCS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq_o
);
    logic [W-1:0] lvl, lvl_d, pend;
    logic [W-1:0] mode, dir, dout, neg, edge_sel, both, mask, clr;

    gsb_sync #(.WIDTH(W), .STAGES(SYNCS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .lvl_o   (lvl),
        .lvl_d_o (lvl_d)
    );

    gsb_regs #(.W(W), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .din      (lvl),
        .pend     (pend),
        .mode     (mode),
        .dir      (dir),
        .dout     (dout),
        .neg      (neg),
        .edge_sel (edge_sel),
        .both     (both),
        .mask     (mask),
        .clr      (clr)
    );

    for (genvar i = 0; i < W; i++) begin : g_line
        line_cfg_t cfg;
        assign cfg = '{irq_en: mode[i], neg: neg[i], edge_sel: edge_sel[i], both: both[i]};

        gsb_line_sense u_sense (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg),
            .lvl   (lvl[i]),
            .lvl_d (lvl_d[i]),
            .clr   (clr[i]),
            .pend  (pend[i])
        );
    end

    assign pin_oe  = dir & ~mode;
    assign pin_out = dout & pin_oe;
    assign irq_o   = |(pend & mask);

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R3
    oe_off_in_irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & mode) == '0));

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_st, m_pins, m_pol, m_edg, m_both, m_mode, m_msk;

    always #2 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] q_of(input logic [31:0] p);
        return p ^ m_pol;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] st, input logic [31:0] oldp,
                                         input logic [31:0] newp);
        logic [31:0] q, evt;
        q   = q_of(newp);
        evt = (m_both & (newp ^ oldp)) | (~m_both & q & ~q_of(oldp));
        return m_mode & ((~m_edg & q) | (m_edg & (st | evt)));
    endfunction

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_st = step(m_st, m_pins, v);
        m_pins = v;
    endtask

    task automatic do_clear(input logic [31:0] c);
        wr(8'h14, c);
        @(negedge clk);
        m_st = m_mode & ((~m_edg & q_of(m_pins)) | (m_edg & m_st & ~c));
    endtask

    localparam logic [31:0] PAT0 = 32'h0F0F_3C3C;
    localparam logic [31:0] PAT1 = 32'hFFFF_0000;
    localparam logic [31:0] PAT2 = 32'h1234_5678;
    localparam logic [31:0] PAT3 = 32'h0000_0000;

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] pats [4];
        pats[0] = PAT0; pats[1] = PAT1; pats[2] = PAT2; pats[3] = PAT3;
        m_st = '0; m_pins = '0; m_pol = '0; m_edg = '0; m_both = '0; m_mode = '0; m_msk = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        foreach (pats[k]) begin end
        for (int a = 0; a < 8'h50; a += 4) begin
            rd(8'(a), r);
            chk("R1 reg reset", r, 32'h0);
        end
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 out", pin_out, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2 readback
        wr(8'h00, 32'hDEAD_0001); rd(8'h00, r); chk("R2 mode", r, 32'hDEAD_0001);
        wr(8'h04, 32'hC0FF_EE00); rd(8'h04, r); chk("R2 dir", r, 32'hC0FF_EE00);
        wr(8'h08, 32'h1357_9BDF); rd(8'h08, r); chk("R2 dout", r, 32'h1357_9BDF);
        wr(8'h20, 32'h0000_FFFF); rd(8'h20, r); chk("R2 pol", r, 32'h0000_FFFF);
        wr(8'h24, 32'hFF00_FF00); rd(8'h24, r); chk("R2 edge", r, 32'hFF00_FF00);
        wr(8'h4C, 32'h8000_0001); rd(8'h4C, r); chk("R2 both", r, 32'h8000_0001);
        rd(8'h14, r); chk("R2 clr reads 0", r, 32'h0);
        rd(8'h1C, r); chk("R2 unmask reads 0", r, 32'h0);
        rd(8'h28, r); chk("R2 unmapped", r, 32'h0);

        // R3 output drive sweep
        for (int c = 0; c < 3; c++) begin
            logic [31:0] md, dr, dt;
            md = 32'h0000_00FF << (8 * c);
            dr = 32'hF0F0_F0F0 ^ (32'h1111_1111 * c);
            dt = 32'hAAAA_5555 + c;
            wr(8'h00, md); wr(8'h04, dr); wr(8'h08, dt);
            chk("R3 oe", pin_oe, dr & ~md);
            chk("R3 out", pin_out, dt & dr & ~md);
        end

        // R12 general mode never pends
        wr(8'h00, 32'h0); wr(8'h20, 32'h0); wr(8'h24, 32'h0); wr(8'h4C, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF);
        set_pins(32'hFFFF_FFFF);
        rd(8'h10, r); chk("R12 status", r, 32'h0);
        chk("R12 irq", {31'h0, irq_o}, 32'h0);

        // R4 input sync latency
        @(negedge clk); pin_in = 32'h5A5A_A5A5;
        @(posedge clk); @(negedge clk);
        rd(8'h0C, r); chk("R4 one edge", r, 32'hFFFF_FFFF);
        @(posedge clk); @(negedge clk);
        rd(8'h0C, r); chk("R4 two edges", r, 32'h5A5A_A5A5);
        set_pins(32'h0);

        // R10 mask write paths
        wr(8'h18, 32'h0); rd(8'h18, r); chk("R10 all off", r, 32'h0);
        wr(8'h1C, 32'h0000_FFFF); rd(8'h18, r); chk("R10 unmask", r, 32'h0000_FFFF);
        wr(8'h18, 32'hFFFF_00FF); rd(8'h18, r); chk("R10 and", r, 32'h0000_00FF);
        wr(8'h1C, 32'hF000_0000); rd(8'h18, r); chk("R10 or", r, 32'hF000_00FF);

        // R5 R6 R7 R8 R11 sweep over all sense configurations
        for (int cfg = 0; cfg < 8; cfg++) begin
            m_pol  = {32{cfg[0]}};
            m_edg  = {32{cfg[1]}};
            m_both = {32{cfg[2]}};
            m_msk  = 32'hA5A5_0F0F << cfg;
            wr(8'h00, 32'h0); m_mode = '0; m_st = '0;
            wr(8'h20, m_pol); wr(8'h24, m_edg); wr(8'h4C, m_both);
            wr(8'h18, 32'h0); wr(8'h1C, m_msk);
            set_pins(32'h0);
            wr(8'h00, 32'hFFFF_FFFF); m_mode = 32'hFFFF_FFFF;
            @(negedge clk);
            m_st = m_edg ? 32'h0 : q_of(m_pins);
            foreach (pats[k]) begin
                set_pins(pats[k]);
                rd(8'h10, r);
                chk(cfg[1] ? (cfg[2] ? "R7 two-edge status" : "R6 edge status") : "R5 level status", r, m_st);
                chk("R11 irq", {31'h0, irq_o}, {31'h0, |(m_st & m_msk)});
                do_clear(32'h5555_AAAA);
                rd(8'h10, r);
                chk(cfg[1] ? "R8 clear" : "R5 clear ignored", r, m_st);
            end
        end

        // R9 event and clear at the same edge
        wr(8'h00, 32'h0); wr(8'h20, 32'h0); wr(8'h4C, 32'h0); wr(8'h24, 32'hFFFF_FFFF);
        set_pins(32'h0);
        wr(8'h00, 32'h0000_0001);
        @(negedge clk); pin_in = 32'h1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 8'h14; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk); bus_wr = 1'b0;
        rd(8'h10, r); chk("R9 event wins", r, 32'h1);
        wr(8'h14, 32'h0); rd(8'h10, r); chk("R8 zero write keeps", r, 32'h1);
        wr(8'h14, 32'h1); @(negedge clk); rd(8'h10, r); chk("R8 clear", r, 32'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule